// File: doc/BRIEF.md
# Parallel Flash Program/Erase Sequencer

This block sits on the host side of a parallel NOR-style flash. It drives the flash through a simple synchronous bus-master port. A client hands it one request: an operation (word program, sector erase, block erase or chip erase), a target address, a data word and a completion mode. The sequencer then issues the protective unlock write sequence for that operation, one write per clock. After that it waits for the flash to finish.

There are three ways to wait. Toggle polling reads the target twice and watches bit 6. Data polling reads the target and compares bit 7 with the expected value. Timer mode waits out the worst-case operation time. Completion is asynchronous to the host, so a poll can race with the end of the operation. For that reason, every apparent completion in a polling mode is confirmed by two further reads of the full word. A request ends with a one-cycle done pulse. An error flag comes with that pulse on a timeout or a failed confirmation.

The worst-case times are given as cycle-count parameters: one for a program, one for a sector or block erase, and one for a chip erase.

Top module: `fseq_top`

## Requirements
- R1: `req_ready` is high only while the sequencer is idle. A request is taken on a cycle with `req_valid` and `req_ready` both high. The first write, data 00AAh, is driven in the next cycle. No bus access happens while `req_ready` is high.
- R2: Operation code 0 (word program) issues exactly four writes on consecutive cycles: AAh@5555h, 55h@2AAAh, A0h@5555h, then the request data at the request address.
- R3: Operation codes 1 (sector), 2 (block) and 3 (chip) issue exactly six writes on consecutive cycles: AAh@5555h, 55h@2AAAh, 80h@5555h, AAh@5555h, 55h@2AAAh, then a final write. The final write is 30h at the request address for code 1, 50h at the request address for code 2, and 10h@5555h for code 3. Command data has its upper byte zero.
- R4: Mode code 0 (toggle) reads the request address in pairs. Read data is taken on the cycle after the read is issued. A pair whose bit 6 values are equal counts as an apparent completion; otherwise polling continues.
- R5: Mode code 1 (data polling) reads the request address singly. A read whose bit 7 equals bit 7 of the expected word counts as an apparent completion. The expected word is the request data for a program and FFFFh for any erase.
- R6: After an apparent completion, the sequencer makes two more reads of the request address. It ends without error only if both return the full expected word; otherwise it ends with `err`.
- R7: Mode codes 2 and 3 (timer) make no reads. `done` rises exactly LIMIT+1 cycles after the cycle of the final command write, with `err` low. LIMIT is PROG_CYC for a program, ERASE_CYC for a sector or block erase, and CHIP_CYC for a chip erase.
- R8: In a polling mode, if LIMIT cycles have passed since the final write when a poll read is evaluated, the request ends with `err` high. That happens within LIMIT+4 cycles of the final write.
- R9: `done` is a single-cycle pulse. `err` is high only together with `done`. `req_ready` is high again in the cycle after `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Sequencer idle and able to take a request |
| req_op | input | 2 | 0 program, 1 sector erase, 2 block erase, 3 chip erase |
| req_mode | input | 2 | 0 toggle polling, 1 data polling, 2/3 fixed timer |
| req_addr | input | AW | Target word, sector or block address |
| req_data | input | 16 | Word to program |
| bus_en | output | 1 | Bus access strobe, one cycle per access |
| bus_we | output | 1 | 1 write, 0 read |
| bus_addr | output | AW | Bus word address |
| bus_wdata | output | 16 | Write data |
| bus_rdata | input | 16 | Read data, valid the cycle after a read strobe |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Timeout or confirmation failure, valid with done |

## Verification
Some rules are checked by the assertions on every cycle: the single-cycle `done` pulse, `err` appearing only with `done`, no bus traffic while ready, the first unlock write following acceptance, and the timeout flag holding once raised. Other behaviour can only be shown by the bench's scenarios. These cover the exact write order for each operation, the number of polling reads for a given flash busy time in each mode, the exact timer latency, a verify failure after an apparent pass, and a timeout against a flash that never finishes.

// File: rtl/fseq_pkg.sv
package fseq_pkg;

    localparam int DW = 16;
    localparam int STEPW = 3;
    localparam logic [14:0] KEY_HI = 15'h5555;
    localparam logic [14:0] KEY_LO = 15'h2AAA;

    typedef enum logic [1:0] {
        OP_PROG = 2'd0,
        OP_SECT = 2'd1,
        OP_BLK  = 2'd2,
        OP_CHIP = 2'd3
    } fop_e;

    typedef enum logic [1:0] {
        WM_TOGGLE = 2'd0,
        WM_DATA   = 2'd1,
        WM_TIMER  = 2'd2,
        WM_TIMER2 = 2'd3
    } wmode_e;

    typedef enum logic [3:0] {
        S_IDLE, S_WR, S_TMR,
        S_PA, S_PAC, S_PB, S_PBC,
        S_CA, S_CAC, S_CB, S_CBC,
        S_FIN
    } fstate_e;

    typedef struct packed {
        fop_e          op;
        wmode_e        mode;
        logic [DW-1:0] data;
    } job_t;

    function automatic logic [STEPW-1:0] last_step(fop_e op);
        return (op == OP_PROG) ? STEPW'(3) : STEPW'(5);
    endfunction

    function automatic logic [7:0] final_code(fop_e op);
        case (op)
            OP_SECT: return 8'h30;
            OP_BLK:  return 8'h50;
            OP_CHIP: return 8'h10;
            default: return 8'hA0;
        endcase
    endfunction

    function automatic logic [DW-1:0] expect_word(job_t j);
        return (j.op == OP_PROG) ? j.data : {DW{1'b1}};
    endfunction

endpackage

// File: rtl/fseq_cmd_gen.sv
module fseq_cmd_gen
    import fseq_pkg::*;
#(
    parameter int AW = 20
) (
    input  fop_e               op,
    input  logic [STEPW-1:0]   step,
    input  logic [AW-1:0]      tgt,
    input  logic [DW-1:0]      wdat,
    output logic [AW-1:0]      wr_addr,
    output logic [DW-1:0]      wr_data,
    output logic               last
);
    localparam int PADW = AW - 15;

    logic [AW-1:0] hi_a, lo_a;
    assign hi_a = {{PADW{1'b0}}, KEY_HI};
    assign lo_a = {{PADW{1'b0}}, KEY_LO};
    assign last = (step == last_step(op));

    always_comb begin
        wr_addr = '0;
        wr_data = '0;
        case (step)
            3'd0: begin wr_addr = hi_a; wr_data = 16'h00AA; end
            3'd1: begin wr_addr = lo_a; wr_data = 16'h0055; end
            3'd2: begin
                wr_addr = hi_a;
                wr_data = (op == OP_PROG) ? 16'h00A0 : 16'h0080;
            end
            3'd3: begin
                if (op == OP_PROG) begin
                    wr_addr = tgt;
                    wr_data = wdat;
                end else begin
                    wr_addr = hi_a;
                    wr_data = 16'h00AA;
                end
            end
            3'd4: begin wr_addr = lo_a; wr_data = 16'h0055; end
            3'd5: begin
                wr_addr = (op == OP_CHIP) ? hi_a : tgt;
                wr_data = {8'h00, final_code(op)};
            end
            default: begin wr_addr = '0; wr_data = '0; end
        endcase
    end
endmodule

// File: rtl/fseq_timer.sv
module fseq_timer #(
    parameter int CW = 32
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          clear,
    input  logic          start,
    input  logic [CW-1:0] limit,
    output logic          expired
);
    logic [CW-1:0] cnt;
    logic          running;

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            cnt     <= '0;
            running <= 1'b0;
        end else if (start) begin
            cnt     <= CW'(1);
            running <= 1'b1;
        end else if (running && cnt < limit) begin
            cnt <= cnt + CW'(1);
        end
    end

    assign expired = running && (cnt >= limit);

    // R8
    expire_hold_chk: assert property (@(posedge clk) disable iff (rst)
        expired && !clear && !start |=> expired);
endmodule

// File: rtl/fseq_status_eval.sv
module fseq_status_eval
    import fseq_pkg::*;
(
    input  logic          use_toggle,
    input  logic [DW-1:0] prev_word,
    input  logic [DW-1:0] cur_word,
    input  logic [DW-1:0] exp_word,
    output logic          settled,
    output logic          word_ok
);
    always_comb begin
        if (use_toggle) settled = (cur_word[6] == prev_word[6]);
        else            settled = (cur_word[7] == exp_word[7]);
        word_ok = (cur_word == exp_word);
    end
endmodule

// File: rtl/fseq_top.sv
module fseq_top
    import fseq_pkg::*;
#(
    parameter int AW        = 20,
    parameter int CW        = 32,
    parameter int PROG_CYC  = 2000,
    parameter int ERASE_CYC = 2500000,
    parameter int CHIP_CYC  = 10000000
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          req_valid,
    output logic          req_ready,
    input  logic [1:0]    req_op,
    input  logic [1:0]    req_mode,
    input  logic [AW-1:0] req_addr,
    input  logic [15:0]   req_data,
    output logic          bus_en,
    output logic          bus_we,
    output logic [AW-1:0] bus_addr,
    output logic [15:0]   bus_wdata,
    input  logic [15:0]   bus_rdata,
    output logic          done,
    output logic          err
);
    fstate_e          state;
    job_t             job;
    logic [AW-1:0]    tgt_q;
    logic [STEPW-1:0] step_q;
    logic [DW-1:0]    first_q;
    logic             ok1_q;
    logic             err_q;

    logic [AW-1:0]    cmd_addr;
    logic [DW-1:0]    cmd_data;
    logic             cmd_last;
    logic             tmr_exp;
    logic [CW-1:0]    limit;
    logic             settled, word_ok;
    logic             timer_mode;
    logic [DW-1:0]    exp_word;

    assign timer_mode = job.mode[1];
    assign exp_word   = expect_word(job);

    always_comb begin
        case (job.op)
            OP_PROG: limit = CW'(PROG_CYC);
            OP_CHIP: limit = CW'(CHIP_CYC);
            default: limit = CW'(ERASE_CYC);
        endcase
    end

    fseq_cmd_gen #(.AW(AW)) i_cmd (
        .op(job.op), .step(step_q), .tgt(tgt_q), .wdat(job.data),
        .wr_addr(cmd_addr), .wr_data(cmd_data), .last(cmd_last)
    );

    fseq_timer #(.CW(CW)) i_tmr (
        .clk(clk), .rst(rst),
        .clear(state == S_IDLE),
        .start(state == S_WR && cmd_last),
        .limit(limit),
        .expired(tmr_exp)
    );

    fseq_status_eval i_eval (
        .use_toggle(state == S_PBC),
        .prev_word(first_q),
        .cur_word(bus_rdata),
        .exp_word(exp_word),
        .settled(settled),
        .word_ok(word_ok)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= S_IDLE;
            job     <= '0;
            tgt_q   <= '0;
            step_q  <= '0;
            first_q <= '0;
            ok1_q   <= 1'b0;
            err_q   <= 1'b0;
        end else begin
            case (state)
                S_IDLE: if (req_valid) begin
                    job    <= '{op: fop_e'(req_op), mode: wmode_e'(req_mode), data: req_data};
                    tgt_q  <= req_addr;
                    step_q <= '0;
                    err_q  <= 1'b0;
                    state  <= S_WR;
                end
                S_WR: begin
                    step_q <= step_q + STEPW'(1);
                    if (cmd_last) state <= timer_mode ? S_TMR : S_PA;
                end
                S_TMR: if (tmr_exp) state <= S_FIN;
                S_PA: state <= S_PAC;
                S_PAC: begin
                    if (tmr_exp) begin
                        err_q <= 1'b1;
                        state <= S_FIN;
                    end else if (job.mode == WM_TOGGLE) begin
                        first_q <= bus_rdata;
                        state   <= S_PB;
                    end else begin
                        state <= settled ? S_CA : S_PA;
                    end
                end
                S_PB: state <= S_PBC;
                S_PBC: begin
                    if (tmr_exp) begin
                        err_q <= 1'b1;
                        state <= S_FIN;
                    end else begin
                        state <= settled ? S_CA : S_PA;
                    end
                end
                S_CA:  state <= S_CAC;
                S_CAC: begin
                    ok1_q <= word_ok;
                    state <= S_CB;
                end
                S_CB:  state <= S_CBC;
                S_CBC: begin
                    err_q <= !(ok1_q && word_ok);
                    state <= S_FIN;
                end
                S_FIN:   state <= S_IDLE;
                default: state <= S_IDLE;
            endcase
        end
    end

    assign req_ready = (state == S_IDLE);
    assign bus_we    = (state == S_WR);
    assign bus_en    = (state == S_WR) || (state == S_PA) || (state == S_PB) ||
                       (state == S_CA) || (state == S_CB);
    assign bus_addr  = bus_we ? cmd_addr : tgt_q;
    assign bus_wdata = bus_we ? cmd_data : '0;
    assign done      = (state == S_FIN);
    assign err       = done && err_q;

    // R9
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);
    // R9
    err_with_done_chk: assert property (@(posedge clk) disable iff (rst)
        err |-> done);
    // R9
    ready_after_done_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> req_ready);
    // R1
    ready_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        req_ready |-> !bus_en);
    // R1
    accept_first_write_chk: assert property (@(posedge clk) disable iff (rst)
        req_valid && req_ready |=> bus_en && bus_we && bus_wdata == 16'h00AA);
endmodule

// File: tb/test_fseq_top.sv
module test_fseq_top;
    localparam int AW = 20;
    localparam int PROG_CYC = 40;
    localparam int ERASE_CYC = 60;
    localparam int CHIP_CYC = 80;
    localparam int FOREVER_BUSY = 1000000;

    typedef struct {
        logic [AW-1:0] a;
        logic [15:0]   d;
    } wr_t;

    logic clk = 0, rst = 1;
    logic req_valid = 0;
    logic req_ready;
    logic [1:0] req_op = 0, req_mode = 0;
    logic [AW-1:0] req_addr = 0;
    logic [15:0] req_data = 0;
    logic bus_en, bus_we, done, err;
    logic [AW-1:0] bus_addr;
    logic [15:0] bus_wdata;
    logic [15:0] bus_rdata = 0;

    int n_chk = 0, n_bad = 0;
    int cyc = 0;
    wr_t exp_q[$];
    int busy_left = 0;
    bit tog = 0;
    bit cfg_prog = 0;
    logic [15:0] cfg_data = 0, cfg_final = 0;
    int cfg_busy = 0;
    logic [AW-1:0] cur_tgt = 0;
    int reads = 0;
    int lastwr_cyc = 0;
    bit active = 0;
    bit ready_bad = 0;

    always #5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    fseq_top #(.AW(AW), .CW(32), .PROG_CYC(PROG_CYC), .ERASE_CYC(ERASE_CYC),
               .CHIP_CYC(CHIP_CYC)) i_fseq_top (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
        .req_op(req_op), .req_mode(req_mode), .req_addr(req_addr),
        .req_data(req_data), .bus_en(bus_en), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .done(done), .err(err)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint expv);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, expv);
        end
    endtask

    // Flash model and per-clock comparison against the expected write queue
    always @(negedge clk) begin
        if (!rst) begin
            if (active && req_ready) ready_bad = 1;
            if (bus_en && bus_we) begin
                if (exp_q.size() == 0) begin
                    chk(0, "R2/R3", "unexpected write", bus_wdata, 0);
                end else begin
                    wr_t w;
                    w = exp_q.pop_front();
                    chk(bus_addr == w.a && bus_wdata == w.d, "R2/R3", "write addr/data",
                        {bus_addr, bus_wdata}, {w.a, w.d});
                    if (exp_q.size() == 0) begin
                        busy_left = cfg_busy;
                        tog = 0;
                        lastwr_cyc = cyc;
                    end
                end
            end else if (bus_en) begin
                reads++;
                chk(bus_addr == cur_tgt, "R4", "read address", bus_addr, cur_tgt);
                if (busy_left > 0) begin
                    busy_left--;
                    bus_rdata = {8'h00, (cfg_prog ? ~cfg_data[7] : 1'b0), tog, 6'h00};
                    tog = ~tog;
                end else begin
                    bus_rdata = cfg_final;
                end
            end
        end
    end

    task automatic run_op(input logic [1:0] op, input logic [1:0] mode,
                          input logic [AW-1:0] addr, input logic [15:0] data,
                          input int busy, input logic [15:0] finalv,
                          input bit exp_err, input int exp_reads,
                          input int el_min, input int el_max, input string tag);
        int t;
        int el;
        exp_q.delete();
        exp_q.push_back('{a: AW'(20'h05555), d: 16'h00AA});
        exp_q.push_back('{a: AW'(20'h02AAA), d: 16'h0055});
        if (op == 2'd0) begin
            exp_q.push_back('{a: AW'(20'h05555), d: 16'h00A0});
            exp_q.push_back('{a: addr, d: data});
        end else begin
            exp_q.push_back('{a: AW'(20'h05555), d: 16'h0080});
            exp_q.push_back('{a: AW'(20'h05555), d: 16'h00AA});
            exp_q.push_back('{a: AW'(20'h02AAA), d: 16'h0055});
            case (op)
                2'd1: exp_q.push_back('{a: addr, d: 16'h0030});
                2'd2: exp_q.push_back('{a: addr, d: 16'h0050});
                default: exp_q.push_back('{a: AW'(20'h05555), d: 16'h0010});
            endcase
        end
        cfg_prog = (op == 2'd0);
        cfg_data = data;
        cfg_final = finalv;
        cfg_busy = busy;
        cur_tgt = addr;
        reads = 0;
        ready_bad = 0;
        @(negedge clk);
        req_valid = 1; req_op = op; req_mode = mode; req_addr = addr; req_data = data;
        @(negedge clk);
        req_valid = 0;
        active = 1;
        t = 0;
        while (!done && t < 5000) begin
            @(negedge clk);
            t++;
        end
        active = 0;
        chk(done == 1, "R9", {tag, " done seen"}, done, 1);
        chk(err == exp_err, exp_err ? "R8/R6" : "R6/R7", {tag, " err"}, err, exp_err);
        chk(exp_q.size() == 0, "R2/R3", {tag, " all writes issued"}, exp_q.size(), 0);
        if (exp_reads >= 0)
            chk(reads == exp_reads, mode[1] ? "R7" : "R4/R5/R6", {tag, " read count"},
                reads, exp_reads);
        el = cyc - lastwr_cyc;
        if (el_min >= 0)
            chk(el >= el_min && el <= el_max, exp_err ? "R8" : "R7", {tag, " latency"},
                el, el_min);
        chk(!ready_bad, "R1", {tag, " ready low while busy"}, ready_bad, 0);
        @(negedge clk);
        chk(req_ready == 1 && done == 0, "R9", {tag, " ready after done"},
            {req_ready, done}, 2'b10);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual hung expected finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        // R1 reset state
        chk(req_ready == 1, "R1", "reset ready", req_ready, 1);
        chk(bus_en == 0, "R1", "reset bus idle", bus_en, 0);
        chk(done == 0 && err == 0, "R9", "reset done/err", {done, err}, 0);

        // R2 R4 program, toggle polling, 4 busy reads -> 4 + 2 + 2 confirm
        run_op(2'd0, 2'd0, 20'h12345, 16'h1234, 4, 16'h1234, 0, 8, -1, 0, "prog toggle");
        // R3 R5 sector erase, data polling, 3 busy reads -> 3 + 1 + 2
        run_op(2'd1, 2'd1, 20'h40800, 16'h0000, 3, 16'hFFFF, 0, 6, -1, 0, "sector data");
        // R3 R4 block erase, toggle, 6 busy reads
        run_op(2'd2, 2'd0, 20'h68000, 16'h0000, 6, 16'hFFFF, 0, 10, -1, 0, "block toggle");
        // R3 R7 chip erase, timer mode
        run_op(2'd3, 2'd2, 20'h00000, 16'h0000, 0, 16'hFFFF, 0, 0,
               CHIP_CYC + 1, CHIP_CYC + 1, "chip timer");
        // R2 R7 program, alternate timer code
        run_op(2'd0, 2'd3, 20'h00100, 16'hBEEF, 0, 16'hBEEF, 0, 0,
               PROG_CYC + 1, PROG_CYC + 1, "prog timer");
        // R6 verify failure: bit 7 agrees, full word does not
        run_op(2'd0, 2'd1, 20'h00200, 16'h00C3, 2, 16'h00C2, 1, 5, -1, 0, "prog verify fail");
        // R5 program with data bit 7 = 0
        run_op(2'd0, 2'd1, 20'h00300, 16'h5A01, 5, 16'h5A01, 0, 8, -1, 0, "prog data b7=0");
        // R8 timeout, data polling, sector erase never ends
        run_op(2'd1, 2'd1, 20'h40000, 16'h0000, FOREVER_BUSY, 16'hFFFF, 1, -1,
               ERASE_CYC + 1, ERASE_CYC + 4, "sector timeout");
        // R8 timeout, toggle polling, program never ends
        run_op(2'd0, 2'd0, 20'h00400, 16'h1111, FOREVER_BUSY, 16'h1111, 1, -1,
               PROG_CYC + 1, PROG_CYC + 4, "prog timeout");
        // R6 toggle mode confirm failure after settle
        run_op(2'd2, 2'd0, 20'h70000, 16'h0000, 2, 16'hFFFE, 1, 6, -1, 0, "block verify fail");

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule